// File: doc/BRIEF.md
# I2C Control Register Block with SCL Timing

This block sits between a simple synchronous register bus and an I2C protocol engine. It keeps an 8-bit control word whose five active bits (acknowledge enable, interrupt flag, STOP request, START request and interface enable) software can change only through two write-only addresses. A write to the set address raises every active bit written as one. A write to the clear address lowers every active bit written as one. Zero bits in either write leave the register as it was. The protocol engine has two pulse inputs that clear the interrupt flag and the STOP flag. When a clear and a set of the same bit meet in one cycle, the clear wins.

The block also holds two programmable counts for SCL high time and low time, and drives a free-running SCL waveform from them. The waveform runs while the interface is enabled and a START is requested, and rests high otherwise. While the interface is disabled, STOP is held low, the bus inputs passed to the engine are forced to their idle level, and the slave-state output reports not-addressed.

Top module: `i2c_ctl_regs`

## Requirements
- R1: A write to address 0 sets each control bit in positions 6:2 whose write-data bit is one; bits written as zero keep their value. A read of address 0 returns the control word.
- R2: A write to address 1 clears each control bit in positions 6:2 whose write-data bit is one; bits written as zero keep their value. Address 1 reads as 0.
- R3: A pulse on engClrSi clears the interrupt flag (bit 3), and a pulse on engClrSto clears STOP (bit 4); if a software set of the same bit lands in that cycle, the bit ends cleared.
- R4: After reset the control word reads 0, both SCL count registers (addresses 2 and 3) read 4, and sclOut is 1.
- R5: Control bits 1:0 and 7 always read 0, whatever was written.
- R6: While enable (bit 6) is 0, STOP (bit 4) is 0 even after a set of it, notAddressed is 1, and engSclIn and engSdaIn are 1 whatever sclIn and sdaIn are; while enable is 1 they follow sclIn and sdaIn and notAddressed is 0.
- R7: The SCL high count (address 2) and low count (address 3) read back the last value written.
- R8: While running, sclOut stays high for max(1, high count) cycles and low for max(1, low count) cycles, repeating.
- R9: sclOut is held at 1 unless both enable (bit 6) and START (bit 5) are 1.
- R10: The outputs ctlAa, ctlSi, ctlSto, ctlSta and ctlEn equal control bits 2, 3, 4, 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRdata | output | 8 | Read data for busAddr, combinational |
| engClrSi | input | 1 | Engine pulse clearing the interrupt flag |
| engClrSto | input | 1 | Engine pulse clearing STOP |
| sclIn | input | 1 | SCL line sampled from the bus |
| sdaIn | input | 1 | SDA line sampled from the bus |
| engSclIn | output | 1 | SCL passed to the engine, 1 while disabled |
| engSdaIn | output | 1 | SDA passed to the engine, 1 while disabled |
| sclOut | output | 1 | Generated SCL waveform |
| ctlAa | output | 1 | Acknowledge enable bit |
| ctlSi | output | 1 | Interrupt flag |
| ctlSto | output | 1 | STOP request |
| ctlSta | output | 1 | START request |
| ctlEn | output | 1 | Interface enable |
| notAddressed | output | 1 | Slave-state report, 1 while disabled |

## Verification
The bench walks every combination of the five active bits through the set port and through the clear port, so a design that treats the write as a plain store instead of an OR or AND-NOT shows up at once, as does one that lets STOP survive a set while the interface is off. It drives an engine clear in the same cycle as a software set of the same flag; a design that gives the set priority leaves the flag high. It sweeps both SCL counts from 0 to 4 and measures whole phases; a design that forgets the floor of one stalls SCL or makes a zero-length phase, and an off-by-one in the counter stretches or shortens every phase by a cycle. It also checks that the waveform rests high when only one of enable and START is set.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int CTL_W = 8;
  localparam int BIT_AA  = 2;
  localparam int BIT_SI  = 3;
  localparam int BIT_STO = 4;
  localparam int BIT_STA = 5;
  localparam int BIT_EN  = 6;
  localparam logic [CTL_W-1:0] CTL_MASK = 8'h7C;

  localparam int ADR_CTL_SET = 0;
  localparam int ADR_CTL_CLR = 1;
  localparam int ADR_SCL_HI  = 2;
  localparam int ADR_SCL_LO  = 3;

  typedef struct packed {
    logic setCtl;
    logic clrCtl;
    logic wrHi;
    logic wrLo;
    logic [CTL_W-1:0] data;
  } regStrobe_t;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_NONE = 2'd1,
    SEL_HI   = 2'd2,
    SEL_LO   = 2'd3
  } rdSel_e;
endpackage

// File: rtl/i2c_ctl_decode.sv
module i2c_ctl_decode
  import i2c_ctl_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [CTL_W-1:0]  busWdata,
  output regStrobe_t        strb,
  output rdSel_e            rdSel
);
  logic hitSet, hitClr, hitHi, hitLo;

  assign hitSet = (busAddr == ADDR_W'(ADR_CTL_SET));
  assign hitClr = (busAddr == ADDR_W'(ADR_CTL_CLR));
  assign hitHi  = (busAddr == ADDR_W'(ADR_SCL_HI));
  assign hitLo  = (busAddr == ADDR_W'(ADR_SCL_LO));

  always_comb begin
    strb.setCtl = busWr && hitSet;
    strb.clrCtl = busWr && hitClr;
    strb.wrHi   = busWr && hitHi;
    strb.wrLo   = busWr && hitLo;
    strb.data   = busWdata;
    if (hitSet)      rdSel = SEL_CTL;
    else if (hitHi)  rdSel = SEL_HI;
    else if (hitLo)  rdSel = SEL_LO;
    else             rdSel = SEL_NONE;
  end

  // R1 R2: strobes are mutually exclusive
  always_comb begin
    a_r1_one_strobe: assert ($countones({strb.setCtl, strb.clrCtl, strb.wrHi, strb.wrLo}) <= 1);
  end
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int SCL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [SCL_W-1:0] hiCount,
  input  logic [SCL_W-1:0] loCount,
  output logic             sclOut
);
  localparam logic [SCL_W-1:0] ONE = SCL_W'(1);

  logic [SCL_W-1:0] effHi, effLo, curLen, cnt;
  logic             sclR;

  assign effHi  = (hiCount == '0) ? ONE : hiCount;
  assign effLo  = (loCount == '0) ? ONE : loCount;
  assign curLen = sclR ? effHi : effLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclR <= 1'b1;
      cnt  <= '0;
    end else if (!run) begin
      sclR <= 1'b1;
      cnt  <= '0;
    end else if (cnt >= curLen - ONE) begin
      sclR <= ~sclR;
      cnt  <= '0;
    end else begin
      cnt <= cnt + ONE;
    end
  end

  assign sclOut = sclR;

  // R9: idle generator rests high
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> sclOut);
  // R8: a run always begins in the high phase
  a_r8_start_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |-> sclOut);
endmodule

// File: rtl/i2c_ctl_datapath.sv
module i2c_ctl_datapath
  import i2c_ctl_pkg::*;
#(
  parameter int SCL_W     = 8,
  parameter int SCL_RESET = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strb,
  input  rdSel_e           rdSel,
  input  logic             engClrSi,
  input  logic             engClrSto,
  output logic [CTL_W-1:0] rdata,
  output logic [CTL_W-1:0] ctlBits,
  output logic             sclOut
);
  logic [CTL_W-1:0] ctlReg, ctlNext, setMask, clrMask;
  logic [SCL_W-1:0] hiReg, loReg;
  logic             genRun;

  always_comb begin
    setMask = strb.setCtl ? (strb.data & CTL_MASK) : '0;
    clrMask = strb.clrCtl ? (strb.data & CTL_MASK) : '0;
    clrMask[BIT_SI]  = clrMask[BIT_SI]  | engClrSi;
    clrMask[BIT_STO] = clrMask[BIT_STO] | engClrSto;
    ctlNext = (ctlReg | setMask) & ~clrMask;
    if (!ctlNext[BIT_EN]) ctlNext[BIT_STO] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg <= '0;
      hiReg  <= SCL_W'(SCL_RESET);
      loReg  <= SCL_W'(SCL_RESET);
    end else begin
      ctlReg <= ctlNext;
      if (strb.wrHi) hiReg <= SCL_W'(strb.data);
      if (strb.wrLo) loReg <= SCL_W'(strb.data);
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_CTL:  rdata = ctlReg;
      SEL_HI:   rdata = CTL_W'(hiReg);
      SEL_LO:   rdata = CTL_W'(loReg);
      default:  rdata = '0;
    endcase
  end

  assign ctlBits = ctlReg;
  assign genRun  = ctlReg[BIT_EN] && ctlReg[BIT_STA];

  i2c_scl_gen #(.SCL_W(SCL_W)) u_sclGen (
    .clk     (clk),
    .rstN    (rstN),
    .run     (genRun),
    .hiCount (hiReg),
    .loCount (loReg),
    .sclOut  (sclOut)
  );

  // R3: engine clear wins over anything else in the same cycle
  a_r3_eng_clr_si: assert property (@(posedge clk) disable iff (!rstN)
    engClrSi |=> !ctlBits[BIT_SI]);
  a_r3_eng_clr_sto: assert property (@(posedge clk) disable iff (!rstN)
    engClrSto |=> !ctlBits[BIT_STO]);
  // R2: every bit written as one on the clear port is low afterwards
  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCtl |=> ((ctlBits & $past(strb.data)) == '0));
  // R1: a set of enable without competing clear raises it
  a_r1_set_en: assert property (@(posedge clk) disable iff (!rstN)
    strb.setCtl && strb.data[BIT_EN] |=> ctlBits[BIT_EN]);
  // R6: a STOP set while disabled is dropped
  a_r6_sto_off: assert property (@(posedge clk) disable iff (!rstN)
    !ctlBits[BIT_EN] && !(strb.setCtl && strb.data[BIT_EN]) |=> !ctlBits[BIT_STO]);
  // R7: written high count is read back next cycle
  a_r7_hi_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrHi |=> (hiReg == $past(SCL_W'(strb.data))));
endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int SCL_W     = 8,
  parameter int SCL_RESET = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWdata,
  input  logic              busWr,
  output logic [7:0]        busRdata,
  input  logic              engClrSi,
  input  logic              engClrSto,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              engSclIn,
  output logic              engSdaIn,
  output logic              sclOut,
  output logic              ctlAa,
  output logic              ctlSi,
  output logic              ctlSto,
  output logic              ctlSta,
  output logic              ctlEn,
  output logic              notAddressed
);
  regStrobe_t       strb;
  rdSel_e           rdSel;
  logic [CTL_W-1:0] ctlBits;

  i2c_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busWdata (busWdata),
    .strb     (strb),
    .rdSel    (rdSel)
  );

  i2c_ctl_datapath #(.SCL_W(SCL_W), .SCL_RESET(SCL_RESET)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .rdSel     (rdSel),
    .engClrSi  (engClrSi),
    .engClrSto (engClrSto),
    .rdata     (busRdata),
    .ctlBits   (ctlBits),
    .sclOut    (sclOut)
  );

  assign ctlAa        = ctlBits[BIT_AA];
  assign ctlSi        = ctlBits[BIT_SI];
  assign ctlSto       = ctlBits[BIT_STO];
  assign ctlSta       = ctlBits[BIT_STA];
  assign ctlEn        = ctlBits[BIT_EN];
  assign notAddressed = ~ctlBits[BIT_EN];
  assign engSclIn     = ctlBits[BIT_EN] ? sclIn : 1'b1;
  assign engSdaIn     = ctlBits[BIT_EN] ? sdaIn : 1'b1;
endmodule

// File: tb/i2c_ctl_regs_tb.sv
module i2c_ctl_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic       busWr = 1'b0;
  logic [7:0] busRdata;
  logic       engClrSi = 1'b0, engClrSto = 1'b0;
  logic       sclIn = 1'b1, sdaIn = 1'b1;
  logic       engSclIn, engSdaIn, sclOut;
  logic       ctlAa, ctlSi, ctlSto, ctlSta, ctlEn, notAddressed;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ctl_regs u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWr(busWr),
    .busRdata(busRdata), .engClrSi(engClrSi), .engClrSto(engClrSto),
    .sclIn(sclIn), .sdaIn(sdaIn), .engSclIn(engSclIn), .engSdaIn(engSdaIn),
    .sclOut(sclOut), .ctlAa(ctlAa), .ctlSi(ctlSi), .ctlSto(ctlSto), .ctlSta(ctlSta),
    .ctlEn(ctlEn), .notAddressed(notAddressed)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  function automatic logic [7:0] ctlModel(input logic [7:0] v);
    logic [7:0] e;
    e = v & 8'h7C;
    if (!e[6]) e[4] = 1'b0;
    return e;
  endfunction

  task automatic measure(input int hi, input int lo);
    int lowLen, highLen, guard;
    logic prev;
    busWrite(2'd2, 8'(hi));
    busWrite(2'd3, 8'(lo));
    busWrite(2'd0, 8'h60);
    prev = sclOut;
    guard = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (prev && !sclOut) break;
      prev = sclOut;
      if (guard > 100) break;
    end
    lowLen = 1;
    while (sclOut == 1'b0 && lowLen < 100) begin @(negedge clk); if (!sclOut) lowLen++; end
    highLen = 0;
    while (sclOut == 1'b1 && highLen < 100) begin highLen++; @(negedge clk); end
    check($sformatf("R8 low phase hi=%0d lo=%0d", hi, lo), lowLen, (lo < 1) ? 1 : lo);
    check($sformatf("R8 high phase hi=%0d lo=%0d", hi, lo), highLen, (hi < 1) ? 1 : hi);
    busWrite(2'd1, 8'h60);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    bit allIdle;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R4 reset state
    busRead(2'd0, rd); check("R4 ctl reset", rd, 0);
    busRead(2'd2, rd); check("R4 hi reset", rd, 4);
    busRead(2'd3, rd); check("R4 lo reset", rd, 4);
    check("R4 scl reset", sclOut, 1);
    check("R6 notAddressed after reset", notAddressed, 1);

    // R6 input gating while disabled
    sclIn = 1'b0; sdaIn = 1'b0; #1;
    check("R6 scl gated off", engSclIn, 1);
    check("R6 sda gated off", engSdaIn, 1);

    // R5 reserved bits, R10 outputs
    busWrite(2'd0, 8'hFF);
    busRead(2'd0, rd); check("R5 reserved read 0", rd, 8'h7C);
    check("R10 outputs", {ctlEn, ctlSta, ctlSto, ctlSi, ctlAa}, 5'h1F);
    check("R6 notAddressed enabled", notAddressed, 0);
    check("R6 scl follows", engSclIn, 0);
    check("R6 sda follows", engSdaIn, 0);
    sclIn = 1'b1; sdaIn = 1'b1;
    busRead(2'd1, rd); check("R2 clear addr reads 0", rd, 0);

    // R2 partial clear and zero-write
    busWrite(2'd1, 8'h24);
    busRead(2'd0, rd); check("R2 partial clear", rd, 8'h58);
    busWrite(2'd1, 8'h00);
    busRead(2'd0, rd); check("R2 zero clear no effect", rd, 8'h58);
    busWrite(2'd0, 8'h00);
    busRead(2'd0, rd); check("R1 zero set no effect", rd, 8'h58);

    // R1 R6 sweep of set port from cleared state
    for (int v = 0; v < 32; v++) begin
      busWrite(2'd1, 8'hFF);
      busWrite(2'd0, 8'(v << 2) | 8'h83);
      busRead(2'd0, rd);
      check($sformatf("R1 set sweep v=%0d", v), rd, ctlModel(8'(v << 2)));
      check($sformatf("R10 ctlSto sweep v=%0d", v), ctlSto, rd[4]);
    end

    // R2 R6 sweep of clear port from full state
    for (int v = 0; v < 32; v++) begin
      busWrite(2'd0, 8'h7C);
      busWrite(2'd1, 8'(v << 2));
      busRead(2'd0, rd);
      check($sformatf("R2 clear sweep v=%0d", v), rd, ctlModel(~8'(v << 2)));
    end

    // R6 STOP set while disabled is dropped
    busWrite(2'd1, 8'hFF);
    busWrite(2'd0, 8'h10);
    busRead(2'd0, rd); check("R6 sto held low", rd, 0);
    check("R6 ctlSto off", ctlSto, 0);

    // R3 engine clear beats same-cycle software set
    busWrite(2'd0, 8'h40);
    @(negedge clk);
    busAddr = 2'd0; busWdata = 8'h18; busWr = 1'b1; engClrSi = 1'b1; engClrSto = 1'b1;
    @(negedge clk);
    busWr = 1'b0; engClrSi = 1'b0; engClrSto = 1'b0;
    busRead(2'd0, rd); check("R3 clear beats set", rd, 8'h40);
    busWrite(2'd0, 8'h18);
    @(negedge clk);
    engClrSi = 1'b1;
    @(negedge clk);
    engClrSi = 1'b0;
    busRead(2'd0, rd); check("R3 engine clears SI only", rd, 8'h50);
    @(negedge clk);
    engClrSto = 1'b1;
    @(negedge clk);
    engClrSto = 1'b0;
    busRead(2'd0, rd); check("R3 engine clears STO", rd, 8'h40);
    busWrite(2'd1, 8'hFF);

    // R7 readback
    busWrite(2'd2, 8'hA5);
    busWrite(2'd3, 8'h3C);
    busRead(2'd2, rd); check("R7 hi readback", rd, 8'hA5);
    busRead(2'd3, rd); check("R7 lo readback", rd, 8'h3C);

    // R9 held high with only enable, then with only START
    busWrite(2'd2, 8'd1); busWrite(2'd3, 8'd1);
    busWrite(2'd0, 8'h40);
    allIdle = 1;
    repeat (12) begin @(negedge clk); if (!sclOut) allIdle = 0; end
    check("R9 enable only idle", allIdle, 1);
    busWrite(2'd1, 8'h40);
    busWrite(2'd0, 8'h20);
    allIdle = 1;
    repeat (12) begin @(negedge clk); if (!sclOut) allIdle = 0; end
    check("R9 start only idle", allIdle, 1);
    busWrite(2'd1, 8'hFF);

    // R8 sweep of both counts, zero floors to one
    for (int h = 0; h < 5; h++)
      for (int l = 0; l < 5; l++)
        measure(h, l);
    @(negedge clk);
    check("R9 idle after stop", sclOut, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule